// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block drives the exception bus cycles of a small 8-bit processor with a 16-bit address space. The instruction core pulses `insn_done` when an instruction has completed. At that boundary the sequencer decides whether to run a return-from-interrupt, start an interrupt entry, or do nothing.

An entry saves the processor context on a stack that grows downward, one byte per bus cycle. It then raises the mask bit in the condition code byte and reads the handler address from a vector pair, high byte first. Finally it fetches the first opcode of the handler. A return reads the same five bytes back in reverse order and fetches the opcode at the restored address.

The core supplies its register values at the boundary. When the sequence ends, the sequencer hands back new register values, the fetched opcode and a one-cycle `done` strobe. Memory answers a read in the same cycle the address is driven. Writes take effect at the clock edge that ends a write cycle.

Top module: `exc_sequencer`

## Requirements
- R1: A sequence starts only at a rising clock edge where `insn_done` is high while the block is idle. Pending requests alone cause no bus activity.
- R2: With `rti_req` low, an entry starts only when bit `I_BIT` (default 3) of `ccr_in` is 0 and `irq_pend & irq_en` is nonzero. Otherwise there is no bus activity and no `done`. When `rti_req` is high at the boundary, a return runs even if an enabled request is pending and unmasked.
- R3: The entry begins in the cycle after acceptance with five consecutive write cycles (`bus_we`=1). Taking S as `sp_in`, they write the low PC byte at S, the high PC byte at S-1, `x_in` at S-2, `a_in` at S-3 and the unmodified `ccr_in` at S-4.
- R4: After an entry, `ccr_out` equals `ccr_in` with bit `I_BIT` set. `sp_out` equals S-5, and `a_out` and `x_out` equal the values sampled at acceptance.
- R5: Among the enabled pending sources, the lowest index k wins. The two read cycles after the pushes address `VEC_TOP - 2k` (high byte) and then `VEC_TOP - 2k + 1` (low byte). `VEC_TOP` defaults to 16'hFFFC.
- R6: The two vector bytes, high:low, form the new PC. The next bus cycle is a read at that address. In the following cycle `done` is high for exactly one cycle with `done_ret`=0, `pc_out` equal to the new PC and `opcode_out` equal to the byte read. `bus_act` is low in that cycle.
- R7: A return reads S+1 to S+5 in five consecutive read cycles, taking CCR, A, X, PC high and PC low in that order. It then reads at the restored PC. `done` and `done_ret` are then high, with `ccr_out`, `a_out`, `x_out` and `pc_out` restored, `sp_out` equal to S+5 and `opcode_out` holding the fetched byte.
- R8: `insn_done` and `rti_req` are ignored while a sequence is in progress. The bus schedule and the results are unchanged.
- R9: A request refused because the mask bit is set is taken at a later boundary once the CCR restored by a return has the mask bit clear.
- R10: `bus_we` is high only in cycles where `bus_act` is high. The only writes are the five entry pushes.
- R11: A synchronous active-high `rst` leaves the bus idle and all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Instruction boundary strobe |
| rti_req | input | 1 | Return-from-interrupt request, sampled with insn_done |
| irq_pend | input | NSRC | Pending request per source |
| irq_en | input | NSRC | Enable per source |
| pc_in | input | 16 | Return address to save |
| sp_in | input | 16 | Stack pointer at the boundary |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | Index register |
| ccr_in | input | 8 | Condition code byte |
| bus_act | output | 1 | Bus cycle valid |
| bus_we | output | 1 | Write cycle when high |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the address |
| done | output | 1 | One-cycle completion strobe |
| done_ret | output | 1 | Completed sequence was a return |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| a_out | output | 8 | Accumulator after the sequence |
| x_out | output | 8 | Index register after the sequence |
| ccr_out | output | 8 | Condition code after the sequence |
| opcode_out | output | 8 | Opcode fetched at the new PC |

## Verification
The bound checker watches the following on every cycle:
- writes always carry a valid bus cycle;
- back-to-back writes step down by exactly one address;
- `done` lasts one cycle and coincides with an idle bus, including the cycle in which the bus falls idle;
- every completed entry reports the mask bit set.

The exact sequence of addresses, data and directions, the winning source and its vector, and the values restored by a return can only be shown by the bench scenarios. The same holds for refusing masked, disabled or mid-sequence requests and for deferring a masked request until after a return. The bench compares each of these against a model of its own, driving a byte memory.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PSH_PCL,
    ST_PSH_PCH,
    ST_PSH_X,
    ST_PSH_A,
    ST_PSH_CCR,
    ST_VEC_H,
    ST_VEC_L,
    ST_POP_CCR,
    ST_POP_A,
    ST_POP_X,
    ST_POP_PCH,
    ST_POP_PCL,
    ST_FETCH
  } st_e;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] blocked;
  logic [N-1:0] winner;

  assign blocked[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign blocked[g] = blocked[g-1] | req[g-1];
  end

  assign winner = req & ~blocked;
  assign hit    = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (winner[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int          IW      = 3,
  parameter int          AW      = 16,
  parameter logic [AW-1:0] VEC_TOP = 16'hFFFC
) (
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] vaddr
);
  assign vaddr = VEC_TOP - AW'({idx, 1'b0});
endmodule

// File: rtl/exc_step_fsm.sv
module exc_step_fsm
  import exc_pkg::*;
#(
  parameter int I_BIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_done,
  input  logic          rti_req,
  input  logic          hit,
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] ccr_in,
  output logic          bus_act,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          done_ret,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] x_out,
  output logic [DW-1:0] ccr_out,
  output logic [DW-1:0] opcode_out
);
  localparam logic [DW-1:0] IMASK = DW'(1) << I_BIT;

  st_e           st_q, st_d;
  logic          idle;
  logic [AW-1:0] sp_run, pc_snap, vec_q, pc_new;
  logic [DW-1:0] a_snap, x_snap, ccr_snap, hi_q;
  logic [DW-1:0] a_new, x_new, ccr_new;
  logic          ret_q;
  logic [AW-1:0] cur_sp, cur_pc, tgt;
  logic          nx_act, nx_we;
  logic [AW-1:0] nx_addr, nx_sp;
  logic [DW-1:0] nx_wd;

  assign idle   = (st_q == ST_IDLE);
  assign cur_sp = idle ? sp_in : sp_run;
  assign cur_pc = idle ? pc_in : pc_snap;
  assign tgt    = {hi_q, bus_rdata};

  // cycle schedule
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (insn_done) begin
          if (rti_req)                   st_d = ST_POP_CCR;
          else if (!ccr_in[I_BIT] && hit) st_d = ST_PSH_PCL;
        end
      end
      ST_PSH_PCL: st_d = ST_PSH_PCH;
      ST_PSH_PCH: st_d = ST_PSH_X;
      ST_PSH_X:   st_d = ST_PSH_A;
      ST_PSH_A:   st_d = ST_PSH_CCR;
      ST_PSH_CCR: st_d = ST_VEC_H;
      ST_VEC_H:   st_d = ST_VEC_L;
      ST_VEC_L:   st_d = ST_FETCH;
      ST_POP_CCR: st_d = ST_POP_A;
      ST_POP_A:   st_d = ST_POP_X;
      ST_POP_X:   st_d = ST_POP_PCH;
      ST_POP_PCH: st_d = ST_POP_PCL;
      ST_POP_PCL: st_d = ST_FETCH;
      ST_FETCH:   st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // bus contents for the cycle that follows the edge
  always_comb begin
    nx_act  = 1'b1;
    nx_we   = 1'b0;
    nx_addr = cur_sp;
    nx_wd   = '0;
    nx_sp   = cur_sp;
    unique case (st_d)
      ST_PSH_PCL: begin nx_we = 1'b1; nx_wd = cur_pc[DW-1:0];  nx_sp = cur_sp - AW'(1); end
      ST_PSH_PCH: begin nx_we = 1'b1; nx_wd = cur_pc[AW-1:DW]; nx_sp = cur_sp - AW'(1); end
      ST_PSH_X:   begin nx_we = 1'b1; nx_wd = x_snap;          nx_sp = cur_sp - AW'(1); end
      ST_PSH_A:   begin nx_we = 1'b1; nx_wd = a_snap;          nx_sp = cur_sp - AW'(1); end
      ST_PSH_CCR: begin nx_we = 1'b1; nx_wd = ccr_snap;        nx_sp = cur_sp - AW'(1); end
      ST_VEC_H:   nx_addr = vec_q;
      ST_VEC_L:   nx_addr = vec_q + AW'(1);
      ST_POP_CCR, ST_POP_A, ST_POP_X, ST_POP_PCH, ST_POP_PCL: begin
        nx_addr = cur_sp + AW'(1);
        nx_sp   = cur_sp + AW'(1);
      end
      ST_FETCH:   nx_addr = tgt;
      default: begin
        nx_act  = 1'b0;
        nx_addr = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      bus_act    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      sp_run     <= '0;
      pc_snap    <= '0;
      vec_q      <= '0;
      pc_new     <= '0;
      a_snap     <= '0;
      x_snap     <= '0;
      ccr_snap   <= '0;
      hi_q       <= '0;
      a_new      <= '0;
      x_new      <= '0;
      ccr_new    <= '0;
      ret_q      <= 1'b0;
      done       <= 1'b0;
      done_ret   <= 1'b0;
      pc_out     <= '0;
      sp_out     <= '0;
      a_out      <= '0;
      x_out      <= '0;
      ccr_out    <= '0;
      opcode_out <= '0;
    end else begin
      st_q      <= st_d;
      bus_act   <= nx_act;
      bus_we    <= nx_we;
      bus_addr  <= nx_addr;
      bus_wdata <= nx_wd;
      sp_run    <= nx_sp;
      done      <= 1'b0;
      if (idle && st_d != ST_IDLE) begin
        pc_snap  <= pc_in;
        a_snap   <= a_in;
        x_snap   <= x_in;
        ccr_snap <= ccr_in;
        vec_q    <= vaddr;
        ret_q    <= (st_d == ST_POP_CCR);
        a_new    <= a_in;
        x_new    <= x_in;
        ccr_new  <= ccr_in | IMASK;
      end
      unique case (st_q)
        ST_VEC_H, ST_POP_PCH: hi_q    <= bus_rdata;
        ST_VEC_L, ST_POP_PCL: pc_new  <= tgt;
        ST_POP_CCR:           ccr_new <= bus_rdata;
        ST_POP_A:             a_new   <= bus_rdata;
        ST_POP_X:             x_new   <= bus_rdata;
        ST_FETCH: begin
          done       <= 1'b1;
          done_ret   <= ret_q;
          pc_out     <= pc_new;
          sp_out     <= sp_run;
          a_out      <= a_new;
          x_out      <= x_new;
          ccr_out    <= ccr_new;
          opcode_out <= bus_rdata;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int            NSRC    = 8,
  parameter logic [AW-1:0] VEC_TOP = 16'hFFFC,
  parameter int            I_BIT   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_done,
  input  logic            rti_req,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   sp_in,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   ccr_in,
  output logic            bus_act,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            done,
  output logic            done_ret,
  output logic [AW-1:0]   pc_out,
  output logic [AW-1:0]   sp_out,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [DW-1:0]   ccr_out,
  output logic [DW-1:0]   opcode_out
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic          hit;
  logic [IW-1:0] idx;
  logic [AW-1:0] vaddr;

  exc_prio_pick #(.N(NSRC), .IW(IW)) prio_i (
    .req (irq_pend & irq_en),
    .hit (hit),
    .idx (idx)
  );

  exc_vec_gen #(.IW(IW), .AW(AW), .VEC_TOP(VEC_TOP)) vgen_i (
    .idx   (idx),
    .vaddr (vaddr)
  );

  exc_step_fsm #(.I_BIT(I_BIT)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .rti_req    (rti_req),
    .hit        (hit),
    .vaddr      (vaddr),
    .pc_in      (pc_in),
    .sp_in      (sp_in),
    .a_in       (a_in),
    .x_in       (x_in),
    .ccr_in     (ccr_in),
    .bus_act    (bus_act),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .done       (done),
    .done_ret   (done_ret),
    .pc_out     (pc_out),
    .sp_out     (sp_out),
    .a_out      (a_out),
    .x_out      (x_out),
    .ccr_out    (ccr_out),
    .opcode_out (opcode_out)
  );
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int I_BIT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_act,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          done,
  input logic          done_ret,
  input logic [DW-1:0] ccr_out
);
  // R10
  wr_needs_act_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_act);

  // R3
  push_descend_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && $past(bus_we)) |-> (bus_addr == $past(bus_addr) - AW'(1)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_act);

  // R6
  bus_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_act) |-> done);

  // R4
  entry_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_ret) |-> ccr_out[I_BIT]);
endmodule

bind exc_sequencer exc_sequencer_chk #(
  .AW(exc_pkg::AW), .DW(exc_pkg::DW), .I_BIT(I_BIT)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_act  (bus_act),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .done     (done),
  .done_ret (done_ret),
  .ccr_out  (ccr_out)
);

// File: tb/exc_sequencer_tb.sv
module exc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_done = 1'b0, rti_req = 1'b0;
  logic [7:0]  irq_pend = '0, irq_en = '0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, ccr_in = '0;
  logic        bus_act, bus_we, done, done_ret;
  logic [15:0] bus_addr, pc_out, sp_out;
  logic [7:0]  bus_wdata, bus_rdata, a_out, x_out, ccr_out, opcode_out;
  logic [7:0]  mem [0:255];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  exc_sequencer dut_i (
    .clk(clk), .rst(rst), .insn_done(insn_done), .rti_req(rti_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .pc_in(pc_in), .sp_in(sp_in),
    .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in), .bus_act(bus_act),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .done_ret(done_ret),
    .pc_out(pc_out), .sp_out(sp_out), .a_out(a_out), .x_out(x_out),
    .ccr_out(ccr_out), .opcode_out(opcode_out)
  );

  function automatic logic [15:0] vec_of(input int s);
    return 16'hFFFC - 16'(2 * s);
  endfunction

  function automatic logic [7:0] init_byte(input int k);
    logic [7:0] v;
    v = 8'(k) ^ 8'h5A;
    for (int i = 0; i < 8; i++) begin
      if (8'(k) == vec_of(i)[7:0])         v = 8'h30 + 8'(i);
      if (8'(k) == vec_of(i)[7:0] + 8'd1)  v = 8'h40 + 8'(8 * i);
    end
    return v;
  endfunction

  // byte memory model, low 8 address bits select the byte
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 256; k++) mem[k] <= init_byte(k);
    end else if (bus_act && bus_we) begin
      mem[bus_addr[7:0]] <= bus_wdata;
    end
  end
  assign bus_rdata = mem[bus_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag, input bit we, input logic [15:0] addr, input logic [7:0] wd);
    logic [39:0] a, e;
    a = {14'd0, bus_act, bus_we, bus_addr, (we ? bus_wdata : 8'h00)};
    e = {14'd0, 1'b1, we, addr, (we ? wd : 8'h00)};
    chk(a === e, tag, a, e);
  endtask

  task automatic run_entry(input logic [7:0] pend, input logic [7:0] en, input logic [7:0] ccr,
                           input logic [15:0] sp, input logic [15:0] pc, input logic [7:0] a,
                           input logic [7:0] x, input bit take, input bit poke, input string tag);
    int src;
    logic [15:0] tgt;
    logic [7:0]  op;
    src = -1;
    for (int i = 7; i >= 0; i--) if (pend[i] && en[i]) src = i;
    @(negedge clk);
    irq_pend = pend; irq_en = en; ccr_in = ccr; sp_in = sp; pc_in = pc; a_in = a; x_in = x;
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    if (!take) begin
      for (int c = 0; c < 4; c++) begin
        chk(!bus_act && !done, tag, {38'd0, bus_act, done}, 40'd0);
        @(negedge clk);
      end
      return;
    end
    tgt = {8'h30 + 8'(src), 8'h40 + 8'(8 * src)};
    for (int c = 1; c <= 8; c++) begin
      case (c)
        1: chk_bus("R3 push pc low", 1'b1, sp,          pc[7:0]);
        2: chk_bus("R3 push pc high", 1'b1, sp - 16'd1, pc[15:8]);
        3: chk_bus("R3 push x", 1'b1, sp - 16'd2, x);
        4: chk_bus("R3 push a", 1'b1, sp - 16'd3, a);
        5: chk_bus("R3 push ccr", 1'b1, sp - 16'd4, ccr);
        6: chk_bus("R5 vector high", 1'b0, vec_of(src), 8'h00);
        7: chk_bus("R5 vector low", 1'b0, vec_of(src) + 16'd1, 8'h00);
        default: chk_bus("R6 opcode fetch", 1'b0, tgt, 8'h00);
      endcase
      if (poke && c == 2) begin insn_done = 1'b1; rti_req = 1'b1; end
      @(negedge clk);
      if (poke && c == 2) begin insn_done = 1'b0; rti_req = 1'b0; end
    end
    op = mem[tgt[7:0]];
    chk(done === 1'b1 && done_ret === 1'b0 && !bus_act, "R6 done strobe", {37'd0, done, done_ret, bus_act}, 40'h4);
    chk(pc_out === tgt, "R6 new pc", {24'd0, pc_out}, {24'd0, tgt});
    chk(opcode_out === op, "R6 opcode", {32'd0, opcode_out}, {32'd0, op});
    chk(ccr_out === (ccr | 8'h08), "R4 mask set", {32'd0, ccr_out}, {32'd0, ccr | 8'h08});
    chk({sp_out, a_out, x_out} === {sp - 16'd5, a, x}, "R4 sp/a/x", {8'd0, sp_out, a_out, x_out}, {8'd0, sp - 16'd5, a, x});
    @(negedge clk);
    chk(done === 1'b0, "R6 single pulse", {39'd0, done}, 40'd0);
  endtask

  task automatic run_return(input logic [15:0] sp, input logic [7:0] ccr_drv, input logic [7:0] e_ccr,
                            input logic [7:0] e_a, input logic [7:0] e_x, input logic [15:0] e_pc);
    logic [7:0] op;
    @(negedge clk);
    sp_in = sp; ccr_in = ccr_drv; a_in = 8'hEE; x_in = 8'hDD; pc_in = 16'h0;
    rti_req = 1'b1; insn_done = 1'b1;
    @(negedge clk);
    rti_req = 1'b0; insn_done = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      if (c <= 5) chk_bus("R7 pop read (R2 precedence)", 1'b0, sp + 16'(c), 8'h00);
      else        chk_bus("R7 fetch at restored pc", 1'b0, e_pc, 8'h00);
      @(negedge clk);
    end
    op = mem[e_pc[7:0]];
    chk(done === 1'b1 && done_ret === 1'b1, "R7 done", {38'd0, done, done_ret}, 40'h3);
    chk({ccr_out, a_out, x_out} === {e_ccr, e_a, e_x}, "R7 ccr/a/x", {16'd0, ccr_out, a_out, x_out}, {16'd0, e_ccr, e_a, e_x});
    chk({pc_out, sp_out} === {e_pc, sp + 16'd5}, "R7 pc/sp", {8'd0, pc_out, sp_out}, {8'd0, e_pc, sp + 16'd5});
    chk(opcode_out === op, "R7 opcode", {32'd0, opcode_out}, {32'd0, op});
  endtask

  typedef struct packed {
    logic [7:0]  pend, en, ccr;
    logic [15:0] sp, pc;
    logic [7:0]  a, x;
    logic        take, poke;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{8'h01, 8'h01, 8'h00, 16'h00A0, 16'h5120, 8'h11, 8'h22, 1'b1, 1'b0},
    '{8'h0C, 8'h08, 8'h01, 16'h00B8, 16'h6214, 8'h33, 8'h44, 1'b1, 1'b1},
    '{8'h80, 8'hFF, 8'h00, 16'h00C0, 16'h7318, 8'h55, 8'h66, 1'b1, 1'b0},
    '{8'h06, 8'hFF, 8'hF7, 16'h00D0, 16'h842C, 8'h77, 8'h88, 1'b1, 1'b0},
    '{8'h10, 8'h10, 8'h08, 16'h00A0, 16'h5120, 8'h99, 8'hAA, 1'b0, 1'b0},
    '{8'h20, 8'hDF, 8'h00, 16'h00A0, 16'h5120, 8'hBB, 8'hCC, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk({bus_act, bus_we, done, pc_out, sp_out, opcode_out, ccr_out} === '0, "R11 reset state",
        {bus_act, bus_we, done, pc_out, sp_out, opcode_out}, 40'd0);
    // R1 pending, unmasked, but no boundary strobe
    irq_pend = 8'h01; irq_en = 8'h01; ccr_in = 8'h00;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!bus_act && !done, "R1 no boundary", {38'd0, bus_act, done}, 40'd0);
    end
    irq_pend = '0;
    // table of scenarios; entry 1 also pokes mid-sequence (R8)
    for (int v = 0; v < 6; v++) begin
      run_entry(TBL[v].pend, TBL[v].en, TBL[v].ccr, TBL[v].sp, TBL[v].pc, TBL[v].a, TBL[v].x,
                TBL[v].take, TBL[v].poke, TBL[v].poke ? "R8 ignored poke" : "R2 refused");
      if (TBL[v].take)
        run_return(TBL[v].sp - 16'd5, 8'h08, TBL[v].ccr, TBL[v].a, TBL[v].x, TBL[v].pc);
    end
    // R9 masked request held until the return restores a clear mask
    run_entry(8'h01, 8'h05, 8'h00, 16'h00E0, 16'h5424, 8'h12, 8'h34, 1'b1, 1'b0, "R9 first entry");
    run_entry(8'h04, 8'h05, ccr_out, sp_out, 16'h3050, 8'h01, 8'h02, 1'b0, 1'b0, "R9 held while masked");
    run_return(16'h00DB, 8'h00, 8'h00, 8'h12, 8'h34, 16'h5424);
    run_entry(8'h04, 8'h05, ccr_out, sp_out, pc_out, a_out, x_out, 1'b1, 1'b0, "R9 taken after return");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule